// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the sequential multiply/divide unit of a 32-bit integer core. It holds the two result registers HI and LO, which together form one 64-bit accumulator. It also runs every operation that reads or writes them.

A caller presents an operation through a start/busy handshake. The operation is named by a group bit and a 6-bit function code, and it takes two 32-bit operands, `rs_i` and `rt_i`. Moves into HI or LO complete in one cycle. Reads of HI or LO return the value one cycle after they are accepted, with a result strobe. Multiplies run a shift-add loop whose length is set by a parameter. Divides run a restoring loop that produces one quotient bit per cycle.

While the unit is busy, new requests are ignored. A caller that wants HI or LO must hold its read until `busy_o` falls, and that is how reads stall. The reset input is asynchronous, active low, and its release is expected to be synchronous to `clk`.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset `busy_o` and `res_valid_o` are 0, and reads of HI and LO return 0.
- R2: With group 0, code 0x11 loads HI from `rs_i` and code 0x13 loads LO from `rs_i`. The move takes effect one cycle after acceptance and never raises `busy_o`.
- R3: With group 0, code 0x10 reads HI and code 0x12 reads LO. `res_valid_o` pulses for one cycle in the cycle after acceptance, and `res_o` carries the register value.
- R4: With group 0, code 0x18 (signed) and code 0x19 (unsigned) multiply `rs_i` by `rt_i`. HI receives product bits 63:32 and LO receives bits 31:0. `busy_o` is high for exactly 32/MUL_STEP+1 cycles after acceptance.
- R5: With group 0, code 0x1A (signed) and code 0x1B (unsigned) divide `rs_i` by `rt_i`. LO receives the quotient and HI receives the remainder. Signed division truncates toward zero, and its remainder takes the sign of the dividend. `busy_o` is high for exactly 33 cycles.
- R6: A divide by zero keeps the 33-cycle busy period and then releases `busy_o`.
- R7: With group 1, code 0x00 (signed) and code 0x01 (unsigned) add the 64-bit product to {HI,LO}. The sum wraps modulo 2^64, and a carry passes from LO into HI.
- R8: With group 1, code 0x04 (signed) and code 0x05 (unsigned) subtract the 64-bit product from {HI,LO}, modulo 2^64.
- R9: With group 1, code 0x02 returns the low 32 bits of the signed product on `res_o`. `res_valid_o` pulses in the cycle in which `busy_o` falls, and HI and LO are left unchanged.
- R10: A request presented while `busy_o` is high is ignored.
- R11: Any other group/code pair is ignored: no busy, no result strobe, and HI and LO are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe; accepted when `busy_o` is low |
| grp_i | input | 1 | Code group: 0 = base group, 1 = accumulate group |
| func_i | input | 6 | Function code within the group |
| rs_i | input | 32 | First operand (multiplicand, dividend, or move source) |
| rt_i | input | 32 | Second operand (multiplier or divisor) |
| busy_o | output | 1 | A multiply or divide is in progress |
| res_valid_o | output | 1 | One-cycle strobe marking a new value on `res_o` |
| res_o | output | 32 | Read or low-word product result |

## Verification
A fault in HI or LO stays hidden until the next read. For that reason, every arithmetic case is followed at once by reads of both registers, and each fault shows up one cycle after the read is accepted. Errors in the loop counters show at the ports as a busy period that is off by cycles, so the length of the busy period is measured for every long operation. Errors in sign handling or in the restoring step show as a wrong quotient or remainder in the same read-back. The operand pairs are chosen so that each sign combination, the most negative value, all-ones operands and a carry from LO into HI each occur at least once.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int XLEN = 32;

  typedef enum logic [3:0] {
    K_NONE, K_MFHI, K_MFLO, K_MTHI, K_MTLO,
    K_MULT, K_DIV, K_MADD, K_MSUB, K_MUL3
  } mdu_kind_e;

  typedef struct packed {
    mdu_kind_e kind;
    logic      sgn;
  } mdu_dec_t;

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV} mdu_state_e;
endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
  import mdu_pkg::*;
(
  input  logic       grp_i,
  input  logic [5:0] func_i,
  output mdu_dec_t   dec_o
);
  always_comb begin
    dec_o = '{kind: K_NONE, sgn: 1'b0};
    if (!grp_i) begin
      unique case (func_i)
        6'h10: dec_o.kind = K_MFHI;
        6'h11: dec_o.kind = K_MTHI;
        6'h12: dec_o.kind = K_MFLO;
        6'h13: dec_o.kind = K_MTLO;
        6'h18: dec_o = '{kind: K_MULT, sgn: 1'b1};
        6'h19: dec_o = '{kind: K_MULT, sgn: 1'b0};
        6'h1A: dec_o = '{kind: K_DIV,  sgn: 1'b1};
        6'h1B: dec_o = '{kind: K_DIV,  sgn: 1'b0};
        default: dec_o.kind = K_NONE;
      endcase
    end else begin
      unique case (func_i)
        6'h00: dec_o = '{kind: K_MADD, sgn: 1'b1};
        6'h01: dec_o = '{kind: K_MADD, sgn: 1'b0};
        6'h02: dec_o = '{kind: K_MUL3, sgn: 1'b1};
        6'h04: dec_o = '{kind: K_MSUB, sgn: 1'b1};
        6'h05: dec_o = '{kind: K_MSUB, sgn: 1'b0};
        default: dec_o.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mdu_mul_seq.sv
module mdu_mul_seq #(
  parameter int XW   = 32,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XW-1:0]   a_i,
  input  logic [XW-1:0]   b_i,
  output logic            done_o,
  output logic [2*XW-1:0] prod_o
);
  localparam int CYC = XW / STEP;
  localparam int CW  = $clog2(CYC + 1);

  logic [2*XW-1:0] acc_q, acc_d, mcd_q, mcd_d;
  logic [XW-1:0]   mpl_q, mpl_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            done_q, done_d, run_en;

  assign run_en = load_i || (cnt_q != '0);

  always_comb begin
    acc_d  = acc_q;
    mcd_d  = mcd_q;
    mpl_d  = mpl_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (load_i) begin
      acc_d = '0;
      mcd_d = {{XW{1'b0}}, a_i};
      mpl_d = b_i;
      cnt_d = CW'(CYC);
    end else if (cnt_q != '0) begin
      for (int k = 0; k < STEP; k++) begin
        if (mpl_q[k]) acc_d = acc_d + (mcd_q << k);
      end
      mcd_d  = mcd_q << STEP;
      mpl_d  = mpl_q >> STEP;
      cnt_d  = cnt_q - CW'(1);
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mcd_q  <= '0;
      mpl_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (run_en) begin
        acc_q <= acc_d;
        mcd_q <= mcd_d;
        mpl_q <= mpl_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = acc_q;

  // R4
  mul_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mdu_div_seq.sv
module mdu_div_seq #(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [XW-1:0] dvd_i,
  input  logic [XW-1:0] dvs_i,
  output logic          done_o,
  output logic [XW-1:0] quo_o,
  output logic [XW-1:0] rem_o
);
  localparam int CW = $clog2(XW + 1);

  logic [XW-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q;
  logic [XW:0]   trial;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d, run_en;

  assign run_en = load_i || (cnt_q != '0);
  assign trial  = {rem_q, quo_q[XW-1]} - {1'b0, dvs_q};

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (load_i) begin
      rem_d = '0;
      quo_d = dvd_i;
      cnt_d = CW'(XW);
    end else if (cnt_q != '0) begin
      if (!trial[XW]) begin
        rem_d = trial[XW-1:0];
        quo_d = {quo_q[XW-2:0], 1'b1};
      end else begin
        rem_d = {rem_q[XW-2:0], quo_q[XW-1]};
        quo_d = {quo_q[XW-2:0], 1'b0};
      end
      cnt_d  = cnt_q - CW'(1);
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (load_i) dvs_q <= dvs_i;
      if (run_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // R5
  div_rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dvs_q != '0) |-> (rem_q < dvs_q));
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import mdu_pkg::*;
#(
  parameter int MUL_STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        grp_i,
  input  logic [5:0]  func_i,
  input  logic [31:0] rs_i,
  input  logic [31:0] rt_i,
  output logic        busy_o,
  output logic        res_valid_o,
  output logic [31:0] res_o
);
  localparam int DW = XLEN;

  mdu_dec_t   dec;
  mdu_state_e state_q, state_d;
  mdu_kind_e  kind_q;
  logic       pneg_q, rneg_q;
  logic [DW-1:0] hi_q, lo_q, hi_d, lo_d, res_q, res_d;
  logic          hi_en, lo_en, rv_q, rv_d;
  logic          accept, a_neg, b_neg, mul_load, div_load;
  logic [DW-1:0] a_mag, b_mag;
  logic          mul_done, div_done;
  logic [2*DW-1:0] mul_prod, prod_s, acc_sum, acc_dif;
  logic [DW-1:0]   div_quo, div_rem, quo_s, rem_s;

  mdu_decode i_dec (.grp_i(grp_i), .func_i(func_i), .dec_o(dec));

  assign accept   = start_i && (state_q == S_IDLE);
  assign a_neg    = dec.sgn && rs_i[DW-1];
  assign b_neg    = dec.sgn && rt_i[DW-1];
  assign a_mag    = a_neg ? (~rs_i + 1'b1) : rs_i;
  assign b_mag    = b_neg ? (~rt_i + 1'b1) : rt_i;
  assign mul_load = accept && (dec.kind inside {K_MULT, K_MADD, K_MSUB, K_MUL3});
  assign div_load = accept && (dec.kind == K_DIV);

  mdu_mul_seq #(.XW(DW), .STEP(MUL_STEP)) i_mul (
    .clk(clk), .rst_n(rst_n), .load_i(mul_load), .a_i(a_mag), .b_i(b_mag),
    .done_o(mul_done), .prod_o(mul_prod));

  mdu_div_seq #(.XW(DW)) i_div (
    .clk(clk), .rst_n(rst_n), .load_i(div_load), .dvd_i(a_mag), .dvs_i(b_mag),
    .done_o(div_done), .quo_o(div_quo), .rem_o(div_rem));

  assign prod_s  = pneg_q ? (~mul_prod + 1'b1) : mul_prod;
  assign acc_sum = {hi_q, lo_q} + prod_s;
  assign acc_dif = {hi_q, lo_q} - prod_s;
  assign quo_s   = pneg_q ? (~div_quo + 1'b1) : div_quo;
  assign rem_s   = rneg_q ? (~div_rem + 1'b1) : div_rem;

  always_comb begin
    state_d = state_q;
    hi_en = 1'b0;  hi_d = hi_q;
    lo_en = 1'b0;  lo_d = lo_q;
    res_d = res_q; rv_d = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        unique case (dec.kind)
          K_MFHI: begin res_d = hi_q; rv_d = 1'b1; end
          K_MFLO: begin res_d = lo_q; rv_d = 1'b1; end
          K_MTHI: begin hi_en = 1'b1; hi_d = rs_i; end
          K_MTLO: begin lo_en = 1'b1; lo_d = rs_i; end
          K_MULT, K_MADD, K_MSUB, K_MUL3: state_d = S_MUL;
          K_DIV:  state_d = S_DIV;
          default: state_d = S_IDLE;
        endcase
      end
      S_MUL: if (mul_done) begin
        state_d = S_IDLE;
        unique case (kind_q)
          K_MULT: begin hi_en = 1'b1; lo_en = 1'b1; {hi_d, lo_d} = prod_s;  end
          K_MADD: begin hi_en = 1'b1; lo_en = 1'b1; {hi_d, lo_d} = acc_sum; end
          K_MSUB: begin hi_en = 1'b1; lo_en = 1'b1; {hi_d, lo_d} = acc_dif; end
          default: begin res_d = prod_s[DW-1:0]; rv_d = 1'b1; end
        endcase
      end
      S_DIV: if (div_done) begin
        state_d = S_IDLE;
        hi_en = 1'b1; hi_d = rem_s;
        lo_en = 1'b1; lo_d = quo_s;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      pneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      res_q   <= '0;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rv_q    <= rv_d;
      res_q   <= res_d;
      if (accept) begin
        kind_q <= dec.kind;
        pneg_q <= a_neg ^ b_neg;
        rneg_q <= a_neg;
      end
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign res_valid_o = rv_q;
  assign res_o       = res_q;

  // R4
  mul_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_load |=> (busy_o && !res_valid_o));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mul_done && !div_done) |=> ($stable(hi_q) && $stable(lo_q)));

  // R11
  unknown_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.kind == K_NONE) |=>
      (!busy_o && !res_valid_o && $stable(hi_q) && $stable(lo_q)));

  // R5
  engine_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mul_done, div_done}));
endmodule

// File: tb/test_muldiv_hilo.sv
`timescale 1ns/1ps
module test_muldiv_hilo;
  localparam int MUL_STEP = 4;
  localparam int MUL_BUSY = 32 / MUL_STEP + 1;
  localparam int DIV_BUSY = 33;

  logic clk = 1'b0;
  logic rst_n, start, grp;
  logic [5:0] func;
  logic [31:0] rs, rt;
  logic busy_o, res_valid_o;
  logic [31:0] res_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] m_hi, m_lo;

  always #2 clk = ~clk;

  muldiv_hilo #(.MUL_STEP(MUL_STEP)) i_muldiv_hilo (
    .clk(clk), .rst_n(rst_n), .start_i(start), .grp_i(grp), .func_i(func),
    .rs_i(rs), .rt_i(rt), .busy_o(busy_o), .res_valid_o(res_valid_o), .res_o(res_o));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] ref_prod(input bit s, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    if (s) p = longint'($signed(a)) * longint'($signed(b));
    else   p = {32'b0, a} * {32'b0, b};
    return p;
  endfunction

  task automatic issue(input logic g, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; grp = g; func = f; rs = a; rt = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(output int cyc, output logic rv, output logic [31:0] rr);
    cyc = 0;
    while (busy_o) begin
      cyc++;
      @(negedge clk);
    end
    rv = res_valid_o;
    rr = res_o;
  endtask

  task automatic read_reg(input bit hi, input string req, output logic [31:0] v);
    issue(1'b0, hi ? 6'h10 : 6'h12, 32'h0, 32'h0);
    chk({req, " read strobe"}, {63'b0, res_valid_o}, 64'd1);
    v = res_o;
  endtask

  task automatic check_hilo(input string req);
    logic [31:0] h, l;
    read_reg(1'b1, req, h);
    read_reg(1'b0, req, l);
    chk({req, " HI"}, {32'b0, h}, {32'b0, m_hi});
    chk({req, " LO"}, {32'b0, l}, {32'b0, m_lo});
  endtask

  task automatic set_hilo(input logic [31:0] h, input logic [31:0] l);
    issue(1'b0, 6'h11, h, 32'h0);
    chk("R2 move no busy", {63'b0, busy_o}, 64'd0);
    issue(1'b0, 6'h13, l, 32'h0);
    m_hi = h; m_lo = l;
  endtask

  task automatic t_reset;
    chk("R1 busy after reset", {63'b0, busy_o}, 64'd0);
    chk("R1 strobe after reset", {63'b0, res_valid_o}, 64'd0);
    m_hi = 0; m_lo = 0;
    check_hilo("R1");
  endtask

  task automatic t_move;
    set_hilo(32'h1234_5678, 32'h9abc_def0);
    check_hilo("R2/R3");
    @(negedge clk);
    chk("R3 strobe one cycle", {63'b0, res_valid_o}, 64'd0);
  endtask

  task automatic t_mult(input bit s, input logic [31:0] a, input logic [31:0] b);
    int c; logic rv; logic [31:0] rr;
    issue(1'b0, s ? 6'h18 : 6'h19, a, b);
    wait_idle(c, rv, rr);
    chk("R4 multiply busy cycles", 64'(c), 64'(MUL_BUSY));
    {m_hi, m_lo} = ref_prod(s, a, b);
    check_hilo("R4");
  endtask

  task automatic t_div(input bit s, input logic [31:0] a, input logic [31:0] b);
    int c; logic rv; logic [31:0] rr;
    longint qa, qb;
    issue(1'b0, s ? 6'h1A : 6'h1B, a, b);
    wait_idle(c, rv, rr);
    chk("R5 divide busy cycles", 64'(c), 64'(DIV_BUSY));
    if (s) begin
      qa = longint'($signed(a)); qb = longint'($signed(b));
      m_lo = 32'(qa / qb); m_hi = 32'(qa % qb);
    end else begin
      m_lo = a / b; m_hi = a % b;
    end
    check_hilo("R5");
  endtask

  task automatic t_divzero;
    int c; logic rv; logic [31:0] rr;
    issue(1'b0, 6'h1B, 32'd77, 32'd0);
    wait_idle(c, rv, rr);
    chk("R6 divide-by-zero busy cycles", 64'(c), 64'(DIV_BUSY));
    chk("R6 busy released", {63'b0, busy_o}, 64'd0);
  endtask

  task automatic t_acc(input bit sub, input bit s, input logic [31:0] h, input logic [31:0] l,
                       input logic [31:0] a, input logic [31:0] b);
    int c; logic rv; logic [31:0] rr;
    logic [5:0] f;
    set_hilo(h, l);
    f = sub ? (s ? 6'h04 : 6'h05) : (s ? 6'h00 : 6'h01);
    issue(1'b1, f, a, b);
    wait_idle(c, rv, rr);
    chk(sub ? "R8 busy cycles" : "R7 busy cycles", 64'(c), 64'(MUL_BUSY));
    if (sub) {m_hi, m_lo} = {h, l} - ref_prod(s, a, b);
    else     {m_hi, m_lo} = {h, l} + ref_prod(s, a, b);
    check_hilo(sub ? "R8" : "R7");
  endtask

  task automatic t_mul3(input logic [31:0] a, input logic [31:0] b);
    int c; logic rv; logic [31:0] rr;
    logic [63:0] p;
    set_hilo(32'h0bad_f00d, 32'h600d_cafe);
    issue(1'b1, 6'h02, a, b);
    wait_idle(c, rv, rr);
    p = ref_prod(1'b1, a, b);
    chk("R9 busy cycles", 64'(c), 64'(MUL_BUSY));
    chk("R9 strobe at completion", {63'b0, rv}, 64'd1);
    chk("R9 low word", {32'b0, rr}, {32'b0, p[31:0]});
    check_hilo("R9 HI/LO kept");
  endtask

  task automatic t_busy_ignore;
    int c; logic rv; logic [31:0] rr;
    issue(1'b0, 6'h19, 32'd3, 32'd5);
    start = 1'b1; grp = 1'b0; func = 6'h11; rs = 32'hdead_beef;
    @(negedge clk);
    func = 6'h1B; rs = 32'd100; rt = 32'd7;
    @(negedge clk);
    start = 1'b0;
    wait_idle(c, rv, rr);
    chk("R10 busy not extended", 64'(c), 64'(MUL_BUSY - 2));
    m_hi = 0; m_lo = 15;
    check_hilo("R10");
  endtask

  task automatic t_unknown;
    set_hilo(32'hcafe_0001, 32'hcafe_0002);
    issue(1'b0, 6'h3F, 32'h1, 32'h1);
    chk("R11 no busy", {63'b0, busy_o}, 64'd0);
    chk("R11 no strobe", {63'b0, res_valid_o}, 64'd0);
    issue(1'b1, 6'h03, 32'h5, 32'h5);
    chk("R11 no busy grp1", {63'b0, busy_o}, 64'd0);
    chk("R11 no strobe grp1", {63'b0, res_valid_o}, 64'd0);
    check_hilo("R11");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; grp = 1'b0; func = '0; rs = '0; rt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_move();
    t_mult(1'b1, 32'hFFFF_FFF9, 32'd3);
    t_mult(1'b1, 32'h8000_0000, 32'h8000_0000);
    t_mult(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mult(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mult(1'b0, 32'h0001_2345, 32'h0000_0000);
    t_div(1'b1, 32'd7, 32'd2);
    t_div(1'b1, 32'hFFFF_FFF9, 32'd2);
    t_div(1'b1, 32'd7, 32'hFFFF_FFFE);
    t_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
    t_div(1'b0, 32'hFFFF_FFFF, 32'd16);
    t_div(1'b0, 32'd5, 32'd9);
    t_divzero();
    t_acc(1'b0, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'd1, 32'd1);
    t_acc(1'b0, 1'b0, 32'h1, 32'h8000_0000, 32'hFFFF_FFFF, 32'd2);
    t_acc(1'b0, 1'b1, 32'h0, 32'h0000_0004, 32'hFFFF_FFFE, 32'd3);
    t_acc(1'b1, 1'b1, 32'h0, 32'h0, 32'd2, 32'd3);
    t_acc(1'b1, 1'b0, 32'h5, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mul3(32'hFFFF_FFFD, 32'd5);
    t_mul3(32'h0001_0001, 32'h0001_0001);
    t_busy_ignore();
    t_unknown();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule